// File: doc/BRIEF.md
# Cross-Trigger Halt and Clock Stop Controller

This controller sits at the centre of the debug fabric. It gathers breakpoint pulses from processor monitors and interconnect monitors, plus a forced-stop line raised by a debug-port instruction. Each source carries a programmable component mask that says which components it halts. The controller raises the halt outputs for the selected components and waits until every halted component reports idle. Only then does it gate the functional clock of those components that are configured to stop rather than merely halt.

After a guard interval with every clock enable of the stopped components low, it flips the clock select to the test clock and enables it, so the concatenated scan chains can shift out. A resume command unwinds the sequence through the same guard interval back to normal running. A small status output reports the sequencer state and the source that triggered first.

Top module: `dbg_halt_stop_ctl`

## Requirements
- R1: After reset the state code is RUN (0), all halt outputs and test-clock enables are 0, all functional clock enables are 1 and the test clock select is 0.
- R2: In RUN, a pulse on trigger source s whose mask (bits s*N_CMP upward of the mask port) is non-zero moves the state to HALTING (1) on the next edge, with the halt outputs equal to the OR of the masks of all sources firing in that cycle. A trigger whose mask is zero has no effect: the state stays RUN and the halts stay 0.
- R3: On leaving RUN, the status output records the lowest-numbered firing source with a non-zero mask. The code N_SRC means the forced stop alone caused the capture. The value holds until the next capture.
- R4: In HALTING, further triggers OR their masks into the halt outputs and leave the recorded first source unchanged. A cycle with such a request stays in HALTING.
- R5: HALTING moves to CLOCK_OFF (2) only on the edge after every halted component shows idle and at least one halted component has its stop-mode bit at 1. If no halted component is in stop mode, the block stays in HALTING with all functional enables high.
- R6: The forced-stop line halts every component and treats every component as being in stop mode, whatever the masks and mode bits say.
- R7: CLOCK_OFF lasts GAP_CYC cycles. During it, the stopped components have both their functional and their test enables low, and all other components keep their functional enable high.
- R8: In SCAN_CLK (3), the test clock select is 1, the test enables equal the stopped set, and the functional enables are low for the stopped set.
- R9: The test clock select changes only on the edge that leaves CLOCK_OFF.
- R10: Resume returns HALTING to RUN on the next edge with the halts cleared. From SCAN_CLK it passes through GAP_CYC cycles of CLOCK_OFF, with the select still 1, and then reaches RUN with the select at 0 and all functional enables high. Resume is ignored in RUN and in CLOCK_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | N_SRC | Breakpoint pulses, one per source |
| force_stop_i | input | 1 | Stop line from the debug-port instruction |
| route_mask_i | input | N_SRC*N_CMP | Per-source component mask, source s at bits s*N_CMP upward |
| stop_mode_i | input | N_CMP | 1 = stop (gate clock), 0 = halt only, per component |
| idle_i | input | N_CMP | Component reports functional idle |
| resume_i | input | 1 | Resume command |
| halt_o | output | N_CMP | Functional halt request per component |
| func_clk_en_o | output | N_CMP | Functional clock enable per component |
| test_clk_en_o | output | N_CMP | Test clock enable per component |
| test_clk_sel_o | output | 1 | Clock select, 1 = test clock |
| state_o | output | 2 | Sequencer state code |
| first_src_o | output | $clog2(N_SRC+1) | First triggering source |

## Verification
The bench sweeps every source against every mask and every stop-mode pattern. This catches a router that halts the wrong components, or a sequencer that gates clocks for halt-only components or for unselected ones. Directed cases hold one component busy, to catch a design that gates its clock before idle is confirmed. Other cases fire several sources at once, including one with an empty mask, to catch a wrong first-source priority. Further cases add a request while halting, to catch a lost accumulation, and raise the forced stop with empty masks, to catch a stop that depends on routing. Resume is pulsed inside the guard interval: a design that honours it there would toggle the select without the guard gap.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HALTING = 2'd1,
    ST_CLK_OFF = 2'd2,
    ST_SCAN    = 2'd3
  } dhs_state_e;
endpackage

// File: rtl/dhs_trig_router.sv
module dhs_trig_router #(
  parameter int N_SRC = 4,
  parameter int N_CMP = 3,
  parameter int SRC_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]       trig_i,
  input  logic                   force_i,
  input  logic [N_SRC*N_CMP-1:0] route_mask_i,
  output logic [N_CMP-1:0]       req_mask_o,
  output logic                   req_any_o,
  output logic                   force_hit_o,
  output logic [SRC_W-1:0]       first_src_o
);
  logic [N_SRC-1:0] src_hit;
  logic [N_CMP-1:0] src_req [N_SRC];

  // per-source qualification: a trigger counts only if it routes somewhere
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_hit[s] = trig_i[s] & (|route_mask_i[s*N_CMP +: N_CMP]);
    assign src_req[s] = trig_i[s] ? route_mask_i[s*N_CMP +: N_CMP] : '0;
  end

  always_comb begin
    req_mask_o = force_i ? '1 : '0;
    for (int s = 0; s < N_SRC; s++) begin
      req_mask_o = req_mask_o | src_req[s];
    end
  end

  // lowest source wins; forced stop reported only when no source qualified
  always_comb begin
    first_src_o = SRC_W'(N_SRC);
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (src_hit[s]) first_src_o = SRC_W'(s);
    end
  end

  assign req_any_o   = |req_mask_o;
  assign force_hit_o = force_i;
endmodule

// File: rtl/dhs_seq_fsm.sv
module dhs_seq_fsm
  import dhs_pkg::*;
#(
  parameter int N_CMP   = 3,
  parameter int SRC_W   = 3,
  parameter int GAP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] req_mask_i,
  input  logic             req_any_i,
  input  logic             force_hit_i,
  input  logic [SRC_W-1:0] first_src_i,
  input  logic [N_CMP-1:0] idle_i,
  input  logic [N_CMP-1:0] stop_mode_i,
  input  logic             resume_i,
  output dhs_state_e       state_o,
  output logic [N_CMP-1:0] halt_set_o,
  output logic [N_CMP-1:0] stop_set_o,
  output logic             sel_o,
  output logic [SRC_W-1:0] first_src_o
);
  localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(GAP_CYC - 1);

  dhs_state_e       state_q, state_d;
  logic             dir_q, dir_d;        // 1: heading to scan clock
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_CMP-1:0] halt_q, halt_d;
  logic [N_CMP-1:0] stop_q, stop_d;
  logic             force_q, force_d;
  logic             sel_q, sel_d;
  logic [SRC_W-1:0] first_q, first_d;
  logic             all_idle;
  logic [N_CMP-1:0] stop_cand;

  assign all_idle  = &(idle_i | ~halt_q);
  assign stop_cand = halt_q & (stop_mode_i | {N_CMP{force_q}});

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    cnt_d   = cnt_q;
    halt_d  = halt_q;
    stop_d  = stop_q;
    force_d = force_q;
    sel_d   = sel_q;
    first_d = first_q;
    unique case (state_q)
      ST_RUN: begin
        if (req_any_i) begin
          state_d = ST_HALTING;
          halt_d  = req_mask_i;
          force_d = force_hit_i;
          first_d = first_src_i;
        end
      end
      ST_HALTING: begin
        if (resume_i) begin
          state_d = ST_RUN;
          halt_d  = '0;
          force_d = 1'b0;
        end else if (req_any_i) begin
          halt_d  = halt_q | req_mask_i;
          force_d = force_q | force_hit_i;
        end else if (all_idle && (|stop_cand)) begin
          state_d = ST_CLK_OFF;
          dir_d   = 1'b1;
          cnt_d   = CNT_LOAD;
          stop_d  = stop_cand;
        end
      end
      ST_CLK_OFF: begin
        if (cnt_q == '0) begin
          if (dir_q) begin
            state_d = ST_SCAN;
            sel_d   = 1'b1;
          end else begin
            state_d = ST_RUN;
            sel_d   = 1'b0;
            halt_d  = '0;
            stop_d  = '0;
            force_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SCAN: begin
        if (resume_i) begin
          state_d = ST_CLK_OFF;
          dir_d   = 1'b0;
          cnt_d   = CNT_LOAD;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
      halt_q  <= '0;
      stop_q  <= '0;
      force_q <= 1'b0;
      sel_q   <= 1'b0;
      first_q <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      cnt_q   <= cnt_d;
      halt_q  <= halt_d;
      stop_q  <= stop_d;
      force_q <= force_d;
      sel_q   <= sel_d;
      first_q <= first_d;
    end
  end

  assign state_o     = state_q;
  assign halt_set_o  = halt_q;
  assign stop_set_o  = stop_q;
  assign sel_o       = sel_q;
  assign first_src_o = first_q;

  // R5
  idle_before_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLK_OFF && $past(state_q) == ST_HALTING) |-> $past(all_idle));
  // R9
  sel_only_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(state_q) == ST_CLK_OFF);
  // R7
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLK_OFF && cnt_q != '0) |=> state_q == ST_CLK_OFF);
endmodule

// File: rtl/dhs_clk_gate.sv
module dhs_clk_gate
  import dhs_pkg::*;
#(
  parameter int N_CMP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dhs_state_e       state_i,
  input  logic [N_CMP-1:0] stop_set_i,
  output logic [N_CMP-1:0] func_en_o,
  output logic [N_CMP-1:0] test_en_o
);
  logic gated_phase;
  logic scan_phase;

  assign gated_phase = (state_i == ST_CLK_OFF) || (state_i == ST_SCAN);
  assign scan_phase  = (state_i == ST_SCAN);

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign func_en_o[i] = ~(stop_set_i[i] & gated_phase);
    assign test_en_o[i] = stop_set_i[i] & scan_phase;
  end

  // R8
  en_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en_o & test_en_o) == '0);
endmodule

// File: rtl/dbg_halt_stop_ctl.sv
module dbg_halt_stop_ctl
  import dhs_pkg::*;
#(
  parameter int N_SRC   = 4,
  parameter int N_CMP   = 3,
  parameter int GAP_CYC = 2,
  localparam int SRC_W  = $clog2(N_SRC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       trig_i,
  input  logic                   force_stop_i,
  input  logic [N_SRC*N_CMP-1:0] route_mask_i,
  input  logic [N_CMP-1:0]       stop_mode_i,
  input  logic [N_CMP-1:0]       idle_i,
  input  logic                   resume_i,
  output logic [N_CMP-1:0]       halt_o,
  output logic [N_CMP-1:0]       func_clk_en_o,
  output logic [N_CMP-1:0]       test_clk_en_o,
  output logic                   test_clk_sel_o,
  output logic [1:0]             state_o,
  output logic [SRC_W-1:0]       first_src_o
);
  logic [N_CMP-1:0] req_mask;
  logic             req_any;
  logic             force_hit;
  logic [SRC_W-1:0] first_src;
  dhs_state_e       state;
  logic [N_CMP-1:0] stop_set;

  dhs_trig_router #(.N_SRC(N_SRC), .N_CMP(N_CMP), .SRC_W(SRC_W)) u_router (
    .trig_i       (trig_i),
    .force_i      (force_stop_i),
    .route_mask_i (route_mask_i),
    .req_mask_o   (req_mask),
    .req_any_o    (req_any),
    .force_hit_o  (force_hit),
    .first_src_o  (first_src)
  );

  dhs_seq_fsm #(.N_CMP(N_CMP), .SRC_W(SRC_W), .GAP_CYC(GAP_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_mask_i  (req_mask),
    .req_any_i   (req_any),
    .force_hit_i (force_hit),
    .first_src_i (first_src),
    .idle_i      (idle_i),
    .stop_mode_i (stop_mode_i),
    .resume_i    (resume_i),
    .state_o     (state),
    .halt_set_o  (halt_o),
    .stop_set_o  (stop_set),
    .sel_o       (test_clk_sel_o),
    .first_src_o (first_src_o)
  );

  dhs_clk_gate #(.N_CMP(N_CMP)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .stop_set_i (stop_set),
    .func_en_o  (func_clk_en_o),
    .test_en_o  (test_clk_en_o)
  );

  assign state_o = state;

  // R2
  halt_idle_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (halt_o == '0));
  // R8
  sel_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN) |-> test_clk_sel_o);
endmodule

// File: tb/dbg_halt_stop_ctl_bench.sv
`timescale 1ns/1ps
module dbg_halt_stop_ctl_bench;
  localparam int N_SRC = 4;
  localparam int N_CMP = 3;
  localparam int GAP   = 2;
  localparam int SRC_W = $clog2(N_SRC + 1);
  localparam int ALL   = (1 << N_CMP) - 1;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [N_SRC-1:0]       trig;
  logic                   force_stop;
  logic [N_SRC*N_CMP-1:0] rmask;
  logic [N_CMP-1:0]       smode, idle;
  logic                   resume;
  logic [N_CMP-1:0]       halt, fen, ten;
  logic                   sel;
  logic [1:0]             state;
  logic [SRC_W-1:0]       first;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_halt_stop_ctl #(.N_SRC(N_SRC), .N_CMP(N_CMP), .GAP_CYC(GAP)) u_dbg_halt_stop_ctl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .force_stop_i(force_stop),
    .route_mask_i(rmask), .stop_mode_i(smode), .idle_i(idle), .resume_i(resume),
    .halt_o(halt), .func_clk_en_o(fen), .test_clk_en_o(ten),
    .test_clk_sel_o(sel), .state_o(state), .first_src_o(first)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // entered at the negedge of the first CLOCK_OFF cycle; walks to RUN
  task automatic unwind(input int st, input bit poke);
    for (int g = 0; g < GAP; g++) begin
      chk("R7 state", int'(state), 2);
      chk("R7 func_en", int'(fen), ALL & ~st);
      chk("R7 test_en", int'(ten), 0);
      chk("R9 sel low in gap", int'(sel), 0);
      resume = poke && (g == 0);
      @(negedge clk);
      resume = 1'b0;
    end
    chk("R8 state", int'(state), 3);
    chk("R8 sel", int'(sel), 1);
    chk("R8 test_en", int'(ten), st);
    chk("R8 func_en", int'(fen), ALL & ~st);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    for (int g = 0; g < GAP; g++) begin
      chk("R10 state gap", int'(state), 2);
      chk("R10 both low", int'(fen | ten), ALL & ~st);
      chk("R9 sel held", int'(sel), 1);
      @(negedge clk);
    end
    chk("R10 state run", int'(state), 0);
    chk("R10 sel", int'(sel), 0);
    chk("R10 func_en", int'(fen), ALL);
    chk("R10 halt", int'(halt), 0);
  endtask

  initial begin
    rst_n = 1'b0; trig = '0; force_stop = 1'b0; rmask = '0;
    smode = '0; idle = '1; resume = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 state", int'(state), 0);
    chk("R1 halt", int'(halt), 0);
    chk("R1 func_en", int'(fen), ALL);
    chk("R1 test_en", int'(ten), 0);
    chk("R1 sel", int'(sel), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: every source x mask x stop mode
    for (int s = 0; s < N_SRC; s++) begin
      for (int m = 0; m <= ALL; m++) begin
        for (int sm = 0; sm <= ALL; sm++) begin
          rmask = '0;
          rmask[s*N_CMP +: N_CMP] = N_CMP'(m);
          smode = N_CMP'(sm);
          trig[s] = 1'b1;
          @(negedge clk);
          trig = '0;
          if (m == 0) begin
            chk("R2 empty mask state", int'(state), 0);
            chk("R2 empty mask halt", int'(halt), 0);
            continue;
          end
          chk("R2 state", int'(state), 1);
          chk("R2 halt", int'(halt), m);
          chk("R3 first", int'(first), s);
          if ((m & sm) != 0) begin
            @(negedge clk);
            unwind(m & sm, 1'b0);
          end else begin
            repeat (3) @(negedge clk);
            chk("R5 halt-only state", int'(state), 1);
            chk("R5 halt-only func_en", int'(fen), ALL);
            chk("R5 halt-only halt", int'(halt), m);
            resume = 1'b1;
            @(negedge clk);
            resume = 1'b0;
            chk("R10 resume from halting", int'(state), 0);
            chk("R10 halts cleared", int'(halt), 0);
          end
        end
      end
    end

    // resume in RUN has no effect
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    chk("R10 resume in run", int'(state), 0);

    // idle wait: component 0 busy
    rmask = '0; rmask[0 +: N_CMP] = 3'b011; smode = 3'b001; idle = 3'b110;
    trig[0] = 1'b1;
    @(negedge clk);
    trig = '0;
    for (int k = 0; k < 4; k++) begin
      chk("R5 waits for idle", int'(state), 1);
      chk("R5 clock kept", int'(fen), ALL);
      @(negedge clk);
    end
    idle = '1;
    @(negedge clk);
    unwind(3'b001, 1'b0);

    // priority and accumulation
    rmask = '0;
    rmask[1*N_CMP +: N_CMP] = 3'b001;
    rmask[2*N_CMP +: N_CMP] = 3'b010;
    rmask[3*N_CMP +: N_CMP] = 3'b100;
    smode = '0;
    trig = 4'b1011;
    @(negedge clk);
    trig = '0;
    chk("R3 priority first", int'(first), 1);
    chk("R2 OR of masks", int'(halt), 3'b101);
    trig = 4'b0100;
    @(negedge clk);
    trig = '0;
    chk("R4 accumulated halt", int'(halt), 3'b111);
    chk("R4 first kept", int'(first), 1);
    chk("R4 still halting", int'(state), 1);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    chk("R10 back to run", int'(state), 0);

    // forced stop with empty masks, resume poked inside the gap
    rmask = '0; smode = '0;
    force_stop = 1'b1;
    @(negedge clk);
    force_stop = 1'b0;
    chk("R6 state", int'(state), 1);
    chk("R6 halt all", int'(halt), ALL);
    chk("R3 forced code", int'(first), N_SRC);
    @(negedge clk);
    unwind(ALL, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule